// File: doc/BRIEF.md
# Dual-Clock Power Mode Controller

This block sequences the operating modes of a small microcontroller that can run from a fast main oscillator, a slow low-power oscillator, or both. Software changes mode by writing a control word that holds oscillator enables, a clock-source select, and two stop requests. The block accepts only writes that describe a legal neighbouring mode, and it drops all other writes. From the current mode it produces registered clock enables for the CPU and the peripherals, the CPU clock-source select, and the two oscillator enables.

There are two stop modes. In the light stop, only the CPU clock halts, and any interrupt request ends it. In the deep stop, the CPU clock and the peripheral clocks both halt, and only the oscillator and the timebase keep running. A wake request from deep stop takes effect only when the selected timebase source clock has a falling edge. When the CPU leaves either stop, the block tells it how to resume. If interrupts are globally enabled, the CPU enters the interrupt service routine. If not, it continues with the next instruction. After a deep stop that was entered with the timebase enabled, the block also asks for the timebase interrupt latch to be set.

The block also generates a machine-cycle strobe, with one cycle every four source-clock periods. The source clock is the fast clock or the slow clock, whichever the CPU is running on. Everything runs in the fast clock domain. The slow clock and the timebase sources arrive asynchronously and are synchronised inside the block.

Top module: `pwr_mode_seq`

## Requirements
- R1: After synchronous reset the mode code is 0 (single-clock fast mode) with the CPU and peripheral clocks enabled, the fast oscillator on, the slow oscillator off, the fast source selected and no pulse outputs asserted. Mode codes are: 0 fast-only, 1 dual-oscillator fast, 2 dual-oscillator slow, 3 slow-only, 4 light stop, 5 deep stop.
- R2: A control write carries bit0 = fast oscillator on, bit1 = slow oscillator on, bit2 = slow clock select, bit3 = light stop request, bit4 = deep stop request. From mode 0, the write 5'b00011 moves to mode 1 and turns the slow oscillator on. From mode 1, the write 5'b00001 returns to mode 0.
- R3: From mode 1, the write 5'b00111 moves to mode 2 and selects the slow CPU clock. From mode 2, the write 5'b00011 returns to mode 1.
- R4: From mode 2, the write 5'b00110 moves to mode 3 and turns the fast oscillator off. From mode 3, the write 5'b00111 returns to mode 2.
- R5: In mode 2, a write that clears the slow oscillator bit is dropped. The mode and all outputs stay unchanged.
- R6: A write whose oscillator and select bits do not describe mode 0 to 3 is dropped. A write that names a mode not adjacent to the current one is also dropped. Examples: selecting the slow clock from mode 0, or clearing the fast oscillator in mode 1.
- R7: A light stop request written in mode 0 enters mode 4. The CPU clock stops, while the peripheral clocks and the fast oscillator keep running. If bit3 and bit4 are both set, the deep stop wins.
- R8: In mode 4, any bit of the interrupt request vector returns the block to mode 0 on the next edge. At the same time, the block gives a one-cycle resume pulse: the service pulse if the interrupt master enable is 1, the next-instruction pulse if it is 0. The two pulses are never active together.
- R9: A deep stop request written in mode 0 enters mode 5, and the CPU and peripheral clock enables both go low. The fast oscillator stays on.
- R10: Mode 5 is left for mode 0 only when a wake request has been seen and the synchronised selected timebase source then falls. A rising edge, or a falling edge on an unselected source, does not end the deep stop.
- R11: When mode 5 is left, the timebase latch-set pulse is asserted with the return to mode 0 only if the timebase enable was 1 on entry. The timebase service pulse is asserted with it only if the master enable, the timebase individual enable and the timebase enable are all 1.
- R12: Stop requests written outside mode 0 are dropped, and all control writes made during modes 4 and 5 are dropped.
- R13: The machine-cycle strobe pulses once every 4 fast clocks in modes 0 and 1. In modes 2 and 3 it pulses once every 4 rising edges of the slow clock. It never pulses in modes 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, the domain of all logic |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control word: fast osc, slow osc, slow select, light stop, deep stop |
| gie | input | 1 | Interrupt master enable |
| tb_en | input | 1 | Timebase enable |
| tb_ie | input | 1 | Timebase individual interrupt enable |
| irq_req | input | N_IRQ | Enabled pending interrupt requests |
| tb_src | input | N_TB_SRC | Asynchronous timebase source clocks |
| tb_src_sel | input | TB_SEL_W | Selected timebase source |
| slow_clk | input | 1 | Asynchronous slow oscillator clock |
| mode_o | output | 3 | Current mode code |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| cpu_clk_slow | output | 1 | CPU clock source: 1 = slow |
| fosc_en | output | 1 | Fast oscillator enable |
| sosc_en | output | 1 | Slow oscillator enable |
| resume_isr | output | 1 | Pulse: resume into interrupt service |
| resume_next | output | 1 | Pulse: resume at next instruction |
| tb_irq_set | output | 1 | Pulse: set the timebase interrupt latch |
| tb_irq_take | output | 1 | Pulse: timebase interrupt will be serviced |
| mcyc_stb | output | 1 | Machine-cycle strobe |

## Verification
The assertions check several properties on every cycle. Mode 2 only ever moves to its legal neighbours. Deep stop ends only in a cycle that has a synchronised timebase falling edge. Stops are entered only from mode 0. The resume pulses are mutually exclusive and appear only right after a stop. The timebase service pulse never appears without the latch-set pulse. The cycle strobe is silent while the CPU is stopped. The bench scenarios are needed for the exact result of each control write, including which writes are dropped. They are also needed for the choice of resume pulse under each master enable value, the insensitivity to rising and unselected edges, the dependence of the latch pulse on the timebase enable at entry, and the strobe rates on the fast and slow clocks.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    PM_FAST1  = 3'd0,
    PM_FAST2  = 3'd1,
    PM_SLOW2  = 3'd2,
    PM_SLOW1  = 3'd3,
    PM_NAP    = 3'd4,
    PM_DEEP   = 3'd5
  } pm_mode_e;

  // control word layout, msb first
  typedef struct packed {
    logic deep;
    logic nap;
    logic sel_slow;
    logic sosc;
    logic fosc;
  } pm_ctl_t;

  function automatic logic cfg_legal(pm_ctl_t c);
    logic [2:0] t;
    t = {c.fosc, c.sosc, c.sel_slow};
    return (t == 3'b100) || (t == 3'b110) || (t == 3'b111) || (t == 3'b011);
  endfunction

  function automatic pm_mode_e cfg_mode(pm_ctl_t c);
    pm_mode_e m;
    case ({c.fosc, c.sosc, c.sel_slow})
      3'b110:  m = PM_FAST2;
      3'b111:  m = PM_SLOW2;
      3'b011:  m = PM_SLOW1;
      default: m = PM_FAST1;
    endcase
    return m;
  endfunction

  // one step at a time along fast1 - fast2 - slow2 - slow1
  function automatic logic step_ok(pm_mode_e from, pm_mode_e to);
    logic ok;
    case (from)
      PM_FAST1: ok = (to == PM_FAST1) || (to == PM_FAST2);
      PM_FAST2: ok = (to == PM_FAST1) || (to == PM_FAST2) || (to == PM_SLOW2);
      PM_SLOW2: ok = (to == PM_FAST2) || (to == PM_SLOW2) || (to == PM_SLOW1);
      PM_SLOW1: ok = (to == PM_SLOW1) || (to == PM_SLOW2);
      default:  ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic is_stop(pm_mode_e m);
    return (m == PM_NAP) || (m == PM_DEEP);
  endfunction

endpackage

// File: rtl/pms_sync_edge.sv
module pms_sync_edge #(
  parameter int STAGES    = 2,
  parameter bit FALL_EDGE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic edge_o
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              synced;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign synced = sync_q[STAGES-1];

  generate
    if (FALL_EDGE) begin : g_fall
      assign edge_o = last_q & ~synced;
    end else begin : g_rise
      assign edge_o = ~last_q & synced;
    end
  endgenerate

endmodule

// File: rtl/pms_mode_fsm.sv
module pms_mode_fsm
  import pwr_mode_pkg::*;
#(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  pm_ctl_t          ctl_data,
  input  logic             gie,
  input  logic             tb_en,
  input  logic             tb_ie,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic             tb_fall,
  output pm_mode_e         mode_q,
  output pm_mode_e         mode_d,
  output logic             resume_isr,
  output logic             resume_next,
  output logic             tb_irq_set,
  output logic             tb_irq_take
);

  logic any_irq;
  logic wake_pend_q;
  logic tb_armed_q;
  logic leave_stop;
  logic enter_deep;

  assign any_irq = |irq_req;

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      PM_FAST1, PM_FAST2, PM_SLOW2, PM_SLOW1: begin
        if (ctl_wr) begin
          if (ctl_data.deep || ctl_data.nap) begin
            if (mode_q == PM_FAST1)
              mode_d = ctl_data.deep ? PM_DEEP : PM_NAP;
          end else if (cfg_legal(ctl_data) && step_ok(mode_q, cfg_mode(ctl_data))) begin
            mode_d = cfg_mode(ctl_data);
          end
        end
      end
      PM_NAP: begin
        if (any_irq) mode_d = PM_FAST1;
      end
      PM_DEEP: begin
        if ((wake_pend_q || any_irq) && tb_fall) mode_d = PM_FAST1;
      end
      default: mode_d = PM_FAST1;
    endcase
  end

  assign leave_stop = is_stop(mode_q) && (mode_d == PM_FAST1);
  assign enter_deep = (mode_q != PM_DEEP) && (mode_d == PM_DEEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= PM_FAST1;
      wake_pend_q <= 1'b0;
      tb_armed_q  <= 1'b0;
      resume_isr  <= 1'b0;
      resume_next <= 1'b0;
      tb_irq_set  <= 1'b0;
      tb_irq_take <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      resume_isr  <= leave_stop & gie;
      resume_next <= leave_stop & ~gie;
      tb_irq_set  <= leave_stop && (mode_q == PM_DEEP) && tb_armed_q;
      tb_irq_take <= leave_stop && (mode_q == PM_DEEP) && tb_armed_q && gie && tb_ie && tb_en;
      if (enter_deep) tb_armed_q <= tb_en;
      if (mode_q == PM_DEEP && mode_d == PM_DEEP && any_irq) wake_pend_q <= 1'b1;
      else if (mode_d != PM_DEEP) wake_pend_q <= 1'b0;
    end
  end

  AST_SLOW2_NEIGHBOURS: assert property (@(posedge clk) disable iff (rst)
    mode_q == PM_SLOW2 |=> (mode_q == PM_SLOW2 || mode_q == PM_FAST2 || mode_q == PM_SLOW1)); // R5
  AST_DEEP_EXIT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_DEEP && mode_d != PM_DEEP) |-> tb_fall); // R10
  AST_STOP_FROM_FAST1: assert property (@(posedge clk) disable iff (rst)
    (is_stop(mode_d) && !is_stop(mode_q)) |-> mode_q == PM_FAST1); // R12
  AST_RESUME_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({resume_isr, resume_next})); // R8
  AST_RESUME_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    (resume_isr || resume_next) |-> (mode_q == PM_FAST1 &&
      ($past(mode_q) == PM_NAP || $past(mode_q) == PM_DEEP))); // R8
  AST_TB_TAKE_WITH_SET: assert property (@(posedge clk) disable iff (rst)
    tb_irq_take |-> tb_irq_set); // R11

endmodule

// File: rtl/pms_out_reg.sv
module pms_out_reg
  import pwr_mode_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  pm_mode_e mode_d,
  output logic [2:0] mode_o,
  output logic     cpu_clk_en,
  output logic     per_clk_en,
  output logic     cpu_clk_slow,
  output logic     fosc_en,
  output logic     sosc_en
);

  logic [4:0] dec;

  // {cpu, per, slow select, fast osc, slow osc}
  always_comb begin
    case (mode_d)
      PM_FAST1: dec = 5'b11010;
      PM_FAST2: dec = 5'b11011;
      PM_SLOW2: dec = 5'b11111;
      PM_SLOW1: dec = 5'b11101;
      PM_NAP:   dec = 5'b01010;
      PM_DEEP:  dec = 5'b00010;
      default:  dec = 5'b11010;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o       <= 3'd0;
      cpu_clk_en   <= 1'b1;
      per_clk_en   <= 1'b1;
      cpu_clk_slow <= 1'b0;
      fosc_en      <= 1'b1;
      sosc_en      <= 1'b0;
    end else begin
      mode_o <= mode_d;
      {cpu_clk_en, per_clk_en, cpu_clk_slow, fosc_en, sosc_en} <= dec;
    end
  end

endmodule

// File: rtl/pms_mcyc.sv
module pms_mcyc #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run_fast,
  input  logic run_slow,
  input  logic slow_rise,
  output logic mcyc_stb
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          adv;

  assign adv = run_fast || (run_slow && slow_rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      mcyc_stb <= 1'b0;
    end else begin
      mcyc_stb <= 1'b0;
      if (!(run_fast || run_slow)) begin
        cnt_q <= '0;
      end else if (adv) begin
        if (cnt_q == LAST) begin
          cnt_q    <= '0;
          mcyc_stb <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_MCYC_GATED: assert property (@(posedge clk) disable iff (rst)
    mcyc_stb |-> $past(run_fast || run_slow)); // R13

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int N_IRQ       = 8,
  parameter int N_TB_SRC    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int MCYC_DIV    = 4,
  localparam int TB_SEL_W   = (N_TB_SRC > 1) ? $clog2(N_TB_SRC) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ctl_wr,
  input  logic [4:0]          ctl_wdata,
  input  logic                gie,
  input  logic                tb_en,
  input  logic                tb_ie,
  input  logic [N_IRQ-1:0]    irq_req,
  input  logic [N_TB_SRC-1:0] tb_src,
  input  logic [TB_SEL_W-1:0] tb_src_sel,
  input  logic                slow_clk,
  output logic [2:0]          mode_o,
  output logic                cpu_clk_en,
  output logic                per_clk_en,
  output logic                cpu_clk_slow,
  output logic                fosc_en,
  output logic                sosc_en,
  output logic                resume_isr,
  output logic                resume_next,
  output logic                tb_irq_set,
  output logic                tb_irq_take,
  output logic                mcyc_stb
);

  logic [N_TB_SRC-1:0] tb_fall_v;
  logic                tb_fall;
  logic                slow_rise;
  pm_mode_e            mode_q;
  pm_mode_e            mode_d;
  pm_ctl_t             ctl_data;

  assign ctl_data = pm_ctl_t'(ctl_wdata);

  generate
    for (genvar i = 0; i < N_TB_SRC; i++) begin : g_tb_sync
      pms_sync_edge #(.STAGES(SYNC_STAGES), .FALL_EDGE(1'b1)) u_tb_edge (
        .clk     (clk),
        .rst     (rst),
        .async_i (tb_src[i]),
        .edge_o  (tb_fall_v[i])
      );
    end
  endgenerate

  assign tb_fall = tb_fall_v[tb_src_sel];

  pms_sync_edge #(.STAGES(SYNC_STAGES), .FALL_EDGE(1'b0)) u_slow_edge (
    .clk     (clk),
    .rst     (rst),
    .async_i (slow_clk),
    .edge_o  (slow_rise)
  );

  pms_mode_fsm #(.N_IRQ(N_IRQ)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .ctl_wr      (ctl_wr),
    .ctl_data    (ctl_data),
    .gie         (gie),
    .tb_en       (tb_en),
    .tb_ie       (tb_ie),
    .irq_req     (irq_req),
    .tb_fall     (tb_fall),
    .mode_q      (mode_q),
    .mode_d      (mode_d),
    .resume_isr  (resume_isr),
    .resume_next (resume_next),
    .tb_irq_set  (tb_irq_set),
    .tb_irq_take (tb_irq_take)
  );

  pms_out_reg u_out (
    .clk          (clk),
    .rst          (rst),
    .mode_d       (mode_d),
    .mode_o       (mode_o),
    .cpu_clk_en   (cpu_clk_en),
    .per_clk_en   (per_clk_en),
    .cpu_clk_slow (cpu_clk_slow),
    .fosc_en      (fosc_en),
    .sosc_en      (sosc_en)
  );

  pms_mcyc #(.DIV(MCYC_DIV)) u_mcyc (
    .clk       (clk),
    .rst       (rst),
    .run_fast  (mode_q == PM_FAST1 || mode_q == PM_FAST2),
    .run_slow  (mode_q == PM_SLOW2 || mode_q == PM_SLOW1),
    .slow_rise (slow_rise),
    .mcyc_stb  (mcyc_stb)
  );

  AST_STOP_CPU_HALTED: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_NAP || mode_q == PM_DEEP) |-> !cpu_clk_en); // R7

endmodule

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb_top;

  localparam int N_IRQ    = 8;
  localparam int N_TB_SRC = 4;
  localparam int TB_SEL_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_wr = 1'b0;
  logic [4:0] ctl_wdata = '0;
  logic gie = 1'b0, tb_en = 1'b0, tb_ie = 1'b0;
  logic [N_IRQ-1:0] irq_req = '0;
  logic [N_TB_SRC-1:0] tb_src = '1;
  logic [TB_SEL_W-1:0] tb_src_sel = 2'd1;
  logic slow_clk = 1'b0;
  logic [2:0] mode_o;
  logic cpu_clk_en, per_clk_en, cpu_clk_slow, fosc_en, sosc_en;
  logic resume_isr, resume_next, tb_irq_set, tb_irq_take, mcyc_stb;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwr_mode_seq #(.N_IRQ(N_IRQ), .N_TB_SRC(N_TB_SRC)) dut_i (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .gie(gie),
    .tb_en(tb_en), .tb_ie(tb_ie), .irq_req(irq_req), .tb_src(tb_src),
    .tb_src_sel(tb_src_sel), .slow_clk(slow_clk), .mode_o(mode_o),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .cpu_clk_slow(cpu_clk_slow),
    .fosc_en(fosc_en), .sosc_en(sosc_en), .resume_isr(resume_isr),
    .resume_next(resume_next), .tb_irq_set(tb_irq_set), .tb_irq_take(tb_irq_take),
    .mcyc_stb(mcyc_stb)
  );

  typedef struct packed {
    logic [4:0] wd;
    logic [2:0] mode;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{5'b00011, 3'd1},  // R2 fast1 -> fast2
    '{5'b00111, 3'd2},  // R3 fast2 -> slow2
    '{5'b00101, 3'd2},  // R5 slow osc clear blocked
    '{5'b00001, 3'd2},  // R6 non-adjacent target dropped
    '{5'b00110, 3'd3},  // R4 slow2 -> slow1
    '{5'b00100, 3'd3},  // R6 illegal combination dropped
    '{5'b00111, 3'd2},  // R4 slow1 -> slow2
    '{5'b00011, 3'd1},  // R3 slow2 -> fast2
    '{5'b00010, 3'd1},  // R6 fast osc off in fast2 dropped
    '{5'b00001, 3'd0},  // R2 fast2 -> fast1
    '{5'b00101, 3'd0},  // R6 slow select without slow osc dropped
    '{5'b00011, 3'd1},  // R2 back to fast2
    '{5'b01011, 3'd1},  // R12 stop request outside fast1 dropped
    '{5'b00001, 3'd0}   // R2 back to fast1
  };

  // expected {cpu, per, slow sel, fast osc, slow osc} per mode code
  function automatic logic [4:0] exp_outs(logic [2:0] m);
    case (m)
      3'd0: return 5'b11010;
      3'd1: return 5'b11011;
      3'd2: return 5'b11111;
      3'd3: return 5'b11101;
      3'd4: return 5'b01010;
      default: return 5'b00010;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_mode(string req, logic [2:0] m);
    chk(req, {mode_o, cpu_clk_en, per_clk_en, cpu_clk_slow, fosc_en, sosc_en},
        {m, exp_outs(m)});
  endtask

  task automatic wr(logic [4:0] d);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic pulse_irq();
    @(negedge clk);
    irq_req = 8'h10;
    @(negedge clk);
    irq_req = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    int cnt;
    bit seen_m, seen_s, seen_t, seen_r;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_mode("R1", 3'd0);
    chk("R1 pulses", {resume_isr, resume_next, tb_irq_set, tb_irq_take}, 4'b0);

    // R13 fast rate
    repeat (3) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (mcyc_stb) cnt++;
    end
    chk("R13 fast strobe", cnt, 10);

    for (int v = 0; v < NVEC; v++) begin
      wr(VECS[v].wd);
      chk_mode($sformatf("vector %0d (R2..R6,R12)", v), VECS[v].mode);
    end

    // R7 light stop with master enable set
    gie = 1'b1;
    wr(5'b01001);
    chk_mode("R7", 3'd4);
    wr(5'b00011);
    chk_mode("R12 write in stop", 3'd4);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mcyc_stb) cnt++;
    end
    chk("R13 no strobe in stop", cnt, 0);
    pulse_irq();
    chk_mode("R8 wake", 3'd0);
    chk("R8 isr pulse", {resume_isr, resume_next}, 2'b10);
    @(negedge clk);
    chk("R8 one cycle", {resume_isr, resume_next}, 2'b00);

    // R8 master enable clear
    gie = 1'b0;
    wr(5'b01001);
    pulse_irq();
    chk("R8 next pulse", {mode_o, resume_isr, resume_next}, {3'd0, 2'b01});

    // R9 deep stop, R7 priority, R10, R11 with timebase enabled
    gie = 1'b1; tb_en = 1'b1; tb_ie = 1'b1;
    wr(5'b11001);
    chk_mode("R9", 3'd5);
    pulse_irq();
    repeat (10) @(negedge clk);
    chk("R10 no edge", mode_o, 3'd5);
    tb_src[0] = 1'b0;
    repeat (8) @(negedge clk);
    chk("R10 unselected", mode_o, 3'd5);
    tb_src[1] = 1'b0;
    seen_m = 0; seen_s = 0; seen_t = 0; seen_r = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (mode_o == 3'd0) seen_m = 1;
      if (tb_irq_set) seen_s = 1;
      if (tb_irq_take) seen_t = 1;
      if (resume_isr) seen_r = 1;
    end
    chk("R10 exit on fall", seen_m, 1);
    chk("R11 latch set", {seen_s, seen_t}, 2'b11);
    chk("R8 isr after deep", seen_r, 1);

    // R10 rising edge ignored, R11 no latch when timebase off
    tb_en = 1'b0;
    wr(5'b10001);
    pulse_irq();
    tb_src[1] = 1'b1;
    repeat (10) @(negedge clk);
    chk("R10 rising", mode_o, 3'd5);
    tb_src[1] = 1'b0;
    seen_m = 0; seen_s = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (mode_o == 3'd0) seen_m = 1;
      if (tb_irq_set) seen_s = 1;
    end
    chk("R10 exit", seen_m, 1);
    chk("R11 no latch", seen_s, 0);

    // R13 slow rate, R12 stop request in slow mode
    wr(5'b00011);
    wr(5'b00111);
    wr(5'b01111);
    chk_mode("R12 stop in slow", 3'd2);
    cnt = 0;
    for (int i = 0; i < 320; i++) begin
      @(negedge clk);
      if (i % 4 == 0) slow_clk = ~slow_clk;
      if (mcyc_stb) cnt++;
    end
    chk("R13 slow strobe", (cnt >= 9 && cnt <= 11), 1);

    done = 1'b1;
    finish_run();
  end

endmodule